// File: doc/BRIEF.md
# MII Management Command Controller

This block runs one PHY management transaction over the two-wire management pair (MDC clock, MDIO data) each time the CPU writes a 32-bit command word. The word carries the PHY address, the register address, a read/write opcode and, for a write, the 16 data bits. One write launches the whole serial frame. There is no separate "go" bit. While the frame is on the wire, the same word reads back with a busy flag set. When a read completes, the returned data replaces the low half of the word and a read-valid flag is raised. A one-cycle done pulse marks the end of every transaction, read or write.

MDC is produced from the system clock by a parameterised divider. It runs only while a transaction is active and rests high otherwise. MDIO is updated on each falling MDC edge and sampled on each rising one. The frame is sent most significant bit first, in this order: 32 preamble ones, start code `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register address, a two-bit turnaround, then 16 data bits. On a read, the block stops driving MDIO from the turnaround onward so the PHY can answer.

A small table holds one 5-bit PHY address per port. Port n's entry sits at bits [5n+4:5n] of the packed output. Each entry has its own write strobe.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, the command word reads back as all zeros (busy bit 28 clear, read-valid bit 27 clear). Also after reset: MDC is high, MDIO output enable is low, the done pulse is low and every PHY-address table entry is zero.
- R2: For every command, the first 46 driven bit times are sent MSB first with the output enable high, in this order: 32 ones, `0`, `1`, opcode (`1`,`0` when bit 26 is 1 for read; `0`,`1` when bit 26 is 0 for write), PHY address from bits 20:16, then register address from bits 25:21.
- R3: On a write, the turnaround is driven as `1` then `0`, followed by data bits 15:0 MSB first, with the output enable high for all 64 bit times. Once the write completes, bit 27 stays clear and bits 15:0 still hold the written data.
- R4: On a read, the output enable is low from the turnaround through the last data bit. The 16 bits sampled on the rising MDC edges of bit times 48..63 appear MSB first in bits 15:0, and bit 27 is set once the frame ends.
- R5: Busy (bit 28) is set in the cycle after a command write is accepted. It stays set until the frame ends, then clears.
- R6: Each transaction raises the done output for exactly one clock cycle.
- R7: A command write that arrives while busy has no effect: the frame on MDIO and the command fields read back in bits 26:16 are unchanged.
- R8: Accepting a new command clears read-valid (bit 27). Read-valid is never set while busy.
- R9: MDC rests high when idle and has a period of 2*MDC_HALF system clocks while active. The MDIO output value changes only on a falling MDC edge.
- R10: Each PHY-address table entry n is loaded from the 5-bit write data when its own strobe is high. Entries whose strobe is low keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: [15:0] data, [20:16] PHY, [25:21] register, [26] read |
| cmd_rdata | output | 32 | Command word readback with busy [28] and read-valid [27] |
| cmd_done | output | 1 | One-cycle pulse at the end of each transaction |
| addr_we | input | NUM_PORTS | Per-port write strobe for the PHY-address table |
| addr_wdata | input | 5 | PHY address to load |
| phy_addr | output | 5*NUM_PORTS | Packed PHY-address table, port n at [5n+4:5n] |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A bit counter that is off by one shows up directly in the serial output: the header bits captured at each falling MDC edge shift against the expected frame, and the done pulse arrives one MDC period early or late. Both are caught within the first transaction. A stale opcode or a turnaround that is badly placed shows up as the output enable being wrong at bit 46, or as captured read data that is misaligned by one bit in bits 15:0. A busy flag that is lost or stuck shows in the readback one cycle after the command write, or as a second frame or a missing done pulse. Random field values across many reads and writes, plus directed writes issued mid-frame, expose these faults through the ports alone.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;   // first turnaround bit time
    localparam int DATA_POS   = 48;   // first data bit time
    localparam int CNT_W      = $clog2(FRAME_BITS) + 1;

    typedef struct packed {
        logic        rd;
        logic [4:0]  regad;
        logic [4:0]  phy;
        logic [15:0] data;
    } mgmt_cmd_t;

    function automatic logic [FRAME_BITS-1:0] mk_frame(mgmt_cmd_t c);
        return {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01),
                c.phy, c.regad, (c.rd ? 2'b11 : 2'b10), c.data};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic fall_stb,
    output logic rise_stb
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == CW'(HALF_CYC - 1));
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b1;
        end else if (tick) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.mdc <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mdc      = st_q.mdc;
    assign fall_stb = tick && st_q.mdc;
    assign rise_stb = tick && !st_q.mdc;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  mgmt_cmd_t cmd,
    input  logic      fall_stb,
    input  logic      rise_stb,
    input  logic      mdio_i,
    output logic      busy,
    output logic      mdio_o,
    output logic      mdio_oe,
    output logic      done,
    output logic      rvalid,
    output mgmt_cmd_t cur
);
    typedef struct packed {
        logic                  busy;
        logic [CNT_W-1:0]      cnt;     // bit times already driven
        logic [FRAME_BITS-1:0] frame;
        logic                  mdo;
        logic                  oe;
        logic                  done;
        logic                  rvalid;
        mgmt_cmd_t             cur;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
                st_d.frame  = mk_frame(cmd);
                st_d.rvalid = 1'b0;
                st_d.cur    = cmd;
            end
        end else begin
            if (fall_stb && (st_q.cnt < CNT_W'(FRAME_BITS))) begin
                st_d.mdo   = st_q.frame[FRAME_BITS-1];
                st_d.frame = st_q.frame << 1;
                st_d.oe    = !(st_q.cur.rd && (st_q.cnt >= CNT_W'(TA_POS)));
                st_d.cnt   = st_q.cnt + CNT_W'(1);
            end
            if (rise_stb && (st_q.cnt != '0)) begin
                if (st_q.cur.rd && (st_q.cnt > CNT_W'(DATA_POS)))
                    st_d.cur.data = {st_q.cur.data[14:0], mdio_i};
                if (st_q.cnt == CNT_W'(FRAME_BITS)) begin
                    st_d.busy   = 1'b0;
                    st_d.oe     = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.rvalid = st_q.cur.rd;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign mdio_o  = st_q.mdo;
    assign mdio_oe = st_q.oe;
    assign done    = st_q.done;
    assign rvalid  = st_q.rvalid;
    assign cur     = st_q.cur;

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R6
    AST_OE_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !st_q.oe); // R4
    AST_MDIO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mdo != $past(st_q.mdo)) |-> $past(fall_stb)); // R9
    AST_FIELDS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |->
        (st_q.cur.rd == $past(st_q.cur.rd) && st_q.cur.phy == $past(st_q.cur.phy)
         && st_q.cur.regad == $past(st_q.cur.regad))); // R7
    AST_VALID_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rvalid |-> !st_q.busy); // R8

endmodule

// File: rtl/phy_addr_bank.sv
module phy_addr_bank #(
    parameter int NUM_PORTS = 3,
    parameter int AW        = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_PORTS-1:0]    we,
    input  logic [AW-1:0]           wdata,
    output logic [NUM_PORTS*AW-1:0] tbl
);
    localparam int TW = NUM_PORTS * AW;

    logic [TW-1:0] tbl_d, tbl_q;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign tbl_d[g*AW +: AW] = we[g] ? wdata : tbl_q[g*AW +: AW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign tbl = tbl_q;

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int MDC_HALF  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_we,
    input  logic [31:0]            cmd_wdata,
    output logic [31:0]            cmd_rdata,
    output logic                   cmd_done,
    input  logic [NUM_PORTS-1:0]   addr_we,
    input  logic [4:0]             addr_wdata,
    output logic [NUM_PORTS*5-1:0] phy_addr,
    output logic                   mdc,
    output logic                   mdio_o,
    output logic                   mdio_oe,
    input  logic                   mdio_i
);
    mgmt_cmd_t new_cmd, cur_cmd;
    logic      busy, rvalid, fall_stb, rise_stb;
    logic      unused_hi;

    assign new_cmd.data  = cmd_wdata[15:0];
    assign new_cmd.phy   = cmd_wdata[20:16];
    assign new_cmd.regad = cmd_wdata[25:21];
    assign new_cmd.rd    = cmd_wdata[26];
    assign unused_hi     = ^cmd_wdata[31:27];

    mdc_divider #(.HALF_CYC(MDC_HALF)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_we),
        .cmd      (new_cmd),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (cmd_done),
        .rvalid   (rvalid),
        .cur      (cur_cmd)
    );

    phy_addr_bank #(.NUM_PORTS(NUM_PORTS), .AW(5)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (addr_we),
        .wdata (addr_wdata),
        .tbl   (phy_addr)
    );

    assign cmd_rdata = {3'b000, busy, rvalid, cur_cmd.rd, cur_cmd.regad,
                        cur_cmd.phy, cur_cmd.data};

    AST_MDC_REST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mdc); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (!busy && $past(busy))); // R5

endmodule

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb;
    localparam int NP   = 3;
    localparam int HALF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic [31:0]   cmd_rdata;
    logic          cmd_done;
    logic [NP-1:0] addr_we = '0;
    logic [4:0]    addr_wdata = '0;
    logic [NP*5-1:0] phy_addr;
    logic          mdc, mdio_o, mdio_oe;
    logic          mdio_i = 1'b1;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    // behavioural PHY / line monitor state
    logic [15:0] phy_rd = '0;
    int          nfall = 0;
    int          ndone = 0;
    int          last_fall = 0;
    int          spacing_err = 0;
    logic        prev_mdc = 1'b1;
    logic        obs_o  [64];
    logic        obs_oe [64];

    always #2 clk = ~clk;

    mdio_cmd_ctrl #(.NUM_PORTS(NP), .MDC_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .cmd_done(cmd_done), .addr_we(addr_we),
        .addr_wdata(addr_wdata), .phy_addr(phy_addr), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cmd_done) ndone = ndone + 1;
        if (prev_mdc && !mdc) begin
            if (nfall > 0 && (cyc - last_fall) != 2 * HALF) spacing_err = spacing_err + 1;
            last_fall = cyc;
            if (nfall < 64) begin
                obs_o[nfall]  = mdio_o;
                obs_oe[nfall] = mdio_oe;
                if (nfall >= 48) mdio_i = phy_rd[63 - nfall];
                else             mdio_i = 1'b1;
            end
            nfall = nfall + 1;
        end
        prev_mdc = mdc;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy,
                                              logic [4:0] ra, logic [15:0] d);
        logic [63:0] f;
        f = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra,
             rd ? 2'b00 : 2'b10, d};
        return f;
    endfunction

    task automatic run_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] d, input logic [15:0] rdv, input bit mid);
        logic [63:0] f;
        int hdr_bad, tail_bad;
        f = exp_frame(rd, phy, ra, d);
        phy_rd = rdv;
        nfall = 0;
        ndone = 0;
        spacing_err = 0;
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = {5'b0, rd, ra, phy, d};
        @(negedge clk);
        cmd_we = 1'b0;
        chk(cmd_rdata[28] == 1'b1, "R5 busy after accept", {31'b0, cmd_rdata[28]}, 32'd1);
        chk(cmd_rdata[27] == 1'b0, "R8 valid cleared on accept", {31'b0, cmd_rdata[27]}, 32'd0);
        if (mid) begin
            repeat (100) @(negedge clk);
            cmd_we = 1'b1;
            cmd_wdata = ~{5'b0, rd, ra, phy, d};
            @(negedge clk);
            cmd_we = 1'b0;
            chk(cmd_rdata[26:16] == {rd, ra, phy}, "R7 fields kept while busy",
                {21'b0, cmd_rdata[26:16]}, {21'b0, rd, ra, phy});
        end
        while (cmd_rdata[28]) @(negedge clk);
        @(negedge clk);
        hdr_bad = 0;
        tail_bad = 0;
        for (int k = 0; k < 46; k++)
            if (obs_oe[k] !== 1'b1 || obs_o[k] !== f[63-k]) hdr_bad++;
        for (int k = 46; k < 64; k++) begin
            if (rd) begin
                if (obs_oe[k] !== 1'b0) tail_bad++;
            end else if (obs_oe[k] !== 1'b1 || obs_o[k] !== f[63-k]) tail_bad++;
        end
        chk(nfall == 64, "R2 bit time count", nfall, 64);
        chk(hdr_bad == 0, "R2 header bits", hdr_bad, 0);
        if (rd) begin
            chk(tail_bad == 0, "R4 released from turnaround", tail_bad, 0);
            chk(cmd_rdata[27] && cmd_rdata[15:0] == rdv, "R4 read data and valid",
                {15'b0, cmd_rdata[27], cmd_rdata[15:0]}, {15'b0, 1'b1, rdv});
        end else begin
            chk(tail_bad == 0, "R3 turnaround and write data", tail_bad, 0);
            chk(!cmd_rdata[27] && cmd_rdata[15:0] == d, "R3 write readback",
                {15'b0, cmd_rdata[27], cmd_rdata[15:0]}, {16'b0, d});
        end
        chk(ndone == 1, "R6 one done pulse", ndone, 1);
        chk(spacing_err == 0 && mdc && !mdio_oe, "R9 mdc period and idle",
            spacing_err, 0);
        chk(cmd_rdata[28] == 1'b0, "R5 busy cleared at end", {31'b0, cmd_rdata[28]}, 32'd0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1d2c);
        repeat (3) @(negedge clk);
        chk(cmd_rdata == 32'h0, "R1 command word reset", cmd_rdata, 32'h0);
        chk(mdc == 1'b1 && mdio_oe == 1'b0 && cmd_done == 1'b0, "R1 line reset",
            {29'b0, mdc, mdio_oe, cmd_done}, 32'h4);
        chk(phy_addr == '0, "R1 table reset", {17'b0, phy_addr}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 per-port address table
        for (int p = 0; p < NP; p++) begin
            addr_we = NP'(1) << p;
            addr_wdata = 5'(p * 7 + 3);
            @(negedge clk);
        end
        addr_we = '0;
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            chk(phy_addr[p*5 +: 5] == 5'(p * 7 + 3), "R10 table entry",
                {27'b0, phy_addr[p*5 +: 5]}, 32'(5'(p * 7 + 3)));
        addr_we = 3'b010;
        addr_wdata = 5'h1F;
        @(negedge clk);
        addr_we = '0;
        @(negedge clk);
        chk(phy_addr == {5'd17, 5'h1F, 5'd3}, "R10 only strobed entry changes",
            {17'b0, phy_addr}, {17'b0, 5'd17, 5'h1F, 5'd3});

        // directed corners
        run_cmd(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b0);
        run_cmd(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 16'hFFFF, 1'b0);
        run_cmd(1'b1, 5'h15, 5'h0A, 16'h0000, 16'h8001, 1'b0);
        run_cmd(1'b0, 5'h0A, 5'h15, 16'hA5C3, 16'h0000, 1'b1);
        run_cmd(1'b1, 5'h03, 5'h11, 16'h1234, 16'h7E5A, 1'b1);
        run_cmd(1'b0, 5'h07, 5'h02, 16'h5555, 16'h0000, 1'b0);

        // constrained random
        for (int i = 0; i < 24; i++) begin
            run_cmd(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                    16'($urandom), ($urandom % 5) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R5 watchdog: transaction never finished, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule